// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Mode Latch

This block is the slave side of a small serial EEPROM that holds 128 bytes. After reset it stays in a passive, transmit-only state and never drives the data line. The first falling edge it sees on the serial clock switches it, permanently, into bidirectional two-wire operation. From then on it recognizes start and stop conditions, answers a fixed 7-bit device address, and serves byte writes, random reads, current-address reads and sequential reads.

Both bus lines are sampled by a fast system clock through two-flop synchronizers, and all edge and condition detection runs on the synchronized values. The data line is modeled as an input plus an open-drain output-enable. A separate enable input acts only as a write gate: a received byte is stored only if that input is high when the stop condition arrives.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset `bidirMode` is 0. It becomes 1 after the first falling edge of the serial clock and stays 1 until the next reset.
- R2: While `bidirMode` is 0 the block never drives the data line, and a start condition seen in that state is ignored: the bytes that follow get no acknowledge.
- R3: A start condition is SDA falling while SCL is high. A control byte whose upper seven bits are 1010000 is acknowledged by holding SDA low through the ninth clock. Bit 0 selects read (1) or write (0). Any other control byte gets no acknowledge, and the block stays off the bus until the next start.
- R4: In a write, the second byte is the word address, of which only the low 7 bits are used (bit 7 is ignored). The third byte is data. Both are acknowledged.
- R5: A stop condition is SDA rising while SCL is high. Received write data is stored only if `wrEnIn` is high when the stop condition is detected. Its level during the bytes themselves does not matter.
- R6: A read returns the byte at the current address pointer, most significant bit first.
- R7: After each byte read, the pointer advances by one modulo 128, so a sequential read wraps from address 127 to address 0.
- R8: When the master does not acknowledge a read byte, the block releases SDA and stays off the bus until the next start.
- R9: After a write, the pointer stays at the written word address, so a following current-address read returns the byte just written.
- R10: A repeated start returns the block to the control-byte phase and discards any write data not yet committed by a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line from the bus |
| sdaIn | input | 1 | Data line level as seen on the bus |
| wrEnIn | input | 1 | Write gate, sampled at the stop condition |
| sdaOe | output | 1 | When high, the block pulls the data line down |
| sdaOut | output | 1 | Level driven when enabled (always 0, open drain) |
| bidirMode | output | 1 | Mode latch: 1 once the two-wire protocol is active |

## Verification
The bus is driven by a bit-level master model, and every stored byte is read back over the same bus. Separate cases cover a plain write with random read, a current-address read, a write with the gate low, a write where the gate rises only just before the stop, and a word address with bit 7 set. Each of these outcomes depends on a different part of the pointer and commit logic. A sequential read starting at address 127 tells wrap-around apart from overflow. A wrong device address, a master not-acknowledge, a repeated start that abandons write data, and a start sent before the mode switch each check that the block stays off the bus in exactly the cases where it should.

// File: rtl/twe_pkg.sv
package twe_pkg;

  // Strobes from the control FSM to the datapath, one per action.
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic wordAddr;  // load pointer from received byte
    logic holdData;  // park received byte as pending write
    logic loadTx;    // load transmit register from memory
    logic shiftTx;   // advance transmit register
    logic incAddr;   // step pointer after a byte is read
    logic commit;    // write pending byte into memory
  } twe_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_TXACK, ST_SKIP
  } twe_state_t;

  typedef enum logic [1:0] {
    PH_CTRL, PH_WORD, PH_DATA, PH_DONE
  } twe_phase_t;

endpackage

// File: rtl/twe_sync.sv
module twe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES-1:0] sclChain, sdaChain;
  logic sclD, sdaD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclChain <= '1;
      sdaChain <= '1;
      sclD     <= 1'b1;
      sdaD     <= 1'b1;
    end else begin
      sclChain <= {sclChain[STAGES-2:0], sclIn};
      sdaChain <= {sdaChain[STAGES-2:0], sdaIn};
      sclD     <= sclChain[STAGES-1];
      sdaD     <= sdaChain[STAGES-1];
    end
  end

  assign sclS    = sclChain[STAGES-1];
  assign sdaS    = sdaChain[STAGES-1];
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/twe_ctrl.sv
module twe_ctrl
  import twe_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter logic [DATA_W-2:0] DEV_ID = 7'b1010000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startEv,
  input  logic              stopEv,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txMsb,
  output twe_strobe_t       strb,
  output logic              sdaOe,
  output logic              bidirMode
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  twe_state_t st, stN;
  twe_phase_t phase, phN;
  logic [CW-1:0] bitCnt, bitN;
  logic toTx, toTxN, pend, pendN, mAck, mAckN;

  always_comb begin
    strb  = '0;
    stN   = st;
    phN   = phase;
    bitN  = bitCnt;
    toTxN = toTx;
    pendN = pend;
    mAckN = mAck;
    if (stopEv && bidirMode) begin
      strb.commit = pend & wrEn;
      pendN = 1'b0;
      stN   = ST_IDLE;
    end else if (startEv && bidirMode) begin
      stN   = ST_RX;
      phN   = PH_CTRL;
      bitN  = '0;
      pendN = 1'b0;
    end else begin
      unique case (st)
        ST_RX: if (sclRise) begin
          strb.shiftIn = 1'b1;
          if (bitCnt == LAST) stN = ST_RXEND;
          else bitN = bitCnt + 1'b1;
        end
        ST_RXEND: if (sclFall) begin
          bitN  = '0;
          stN   = ST_ACK;
          toTxN = 1'b0;
          unique case (phase)
            PH_CTRL:
              if (rxByte[DATA_W-1:1] == DEV_ID) begin
                toTxN = rxByte[0];
                phN   = PH_WORD;
              end else stN = ST_SKIP;
            PH_WORD: begin
              strb.wordAddr = 1'b1;
              phN = PH_DATA;
            end
            PH_DATA: begin
              strb.holdData = 1'b1;
              pendN = 1'b1;
              phN   = PH_DONE;
            end
            default: stN = ST_SKIP;
          endcase
        end
        ST_ACK: if (sclFall) begin
          if (toTx) begin
            strb.loadTx = 1'b1;
            stN = ST_TX;
          end else stN = ST_RX;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == LAST) begin
            strb.incAddr = 1'b1;
            bitN = '0;
            stN  = ST_TXACK;
          end else begin
            strb.shiftTx = 1'b1;
            bitN = bitCnt + 1'b1;
          end
        end
        ST_TXACK: begin
          if (sclRise) mAckN = ~sdaS;
          if (sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              stN = ST_TX;
            end else stN = ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st        <= ST_IDLE;
      phase     <= PH_CTRL;
      bitCnt    <= '0;
      toTx      <= 1'b0;
      pend      <= 1'b0;
      mAck      <= 1'b0;
      bidirMode <= 1'b0;
    end else begin
      st     <= stN;
      phase  <= phN;
      bitCnt <= bitN;
      toTx   <= toTxN;
      pend   <= pendN;
      mAck   <= mAckN;
      if (sclFall) bidirMode <= 1'b1;
    end
  end

  assign sdaOe = (st == ST_ACK) || (st == ST_TX && !txMsb);
endmodule

// File: rtl/twe_dpath.sv
module twe_dpath
  import twe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaS,
  input  twe_strobe_t       strb,
  output logic [DATA_W-1:0] rxByte,
  output logic              txMsb,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rxSh, txSh, pendData;
  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh     <= '0;
      txSh     <= '1;
      pendData <= '0;
      addrQ    <= '0;
    end else begin
      if (strb.shiftIn)  rxSh     <= {rxSh[DATA_W-2:0], sdaS};
      if (strb.wordAddr) addrQ    <= rxSh[ADDR_W-1:0];
      if (strb.holdData) pendData <= rxSh;
      if (strb.incAddr)  addrQ    <= addrQ + 1'b1;
      if (strb.loadTx)   txSh     <= mem[addrQ];
      else if (strb.shiftTx) txSh <= {txSh[DATA_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) mem[addrQ] <= pendData;
  end

  assign rxByte  = rxSh;
  assign txMsb   = txSh[DATA_W-1];
  assign curAddr = addrQ;
endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [DATA_W-2:0] DEV_ID = 7'b1010000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wrEnIn,
  output logic sdaOe,
  output logic sdaOut,
  output logic bidirMode
);
  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv, txMsb;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] curAddr;
  twe_strobe_t strb;

  twe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  twe_ctrl #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .startEv(startEv), .stopEv(stopEv),
    .wrEn(wrEnIn), .rxByte(rxByte), .txMsb(txMsb), .strb(strb),
    .sdaOe(sdaOe), .bidirMode(bidirMode)
  );

  twe_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strb(strb),
    .rxByte(rxByte), .txMsb(txMsb), .curAddr(curAddr)
  );

  assign sdaOut = 1'b0;
endmodule

// File: rtl/twe_checker.sv
module twe_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclS,
  input logic              sdaS,
  input logic              sdaOe,
  input logic              bidirMode,
  input logic              wrEn,
  input logic              commitStb,
  input logic              incStb,
  input logic [ADDR_W-1:0] curAddr
);
  assert_mode_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    bidirMode |=> bidirMode);

  assert_quiet_before_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    !bidirMode |-> !sdaOe);

  assert_oe_steady_scl_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe));

  assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (sclS && $past(sclS) && sdaS && !$past(sdaS) && wrEn));

  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    incStb |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)));
endmodule

bind twowire_eeprom twe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS), .sdaOe(sdaOe),
  .bidirMode(bidirMode), .wrEn(wrEnIn), .commitStb(strb.commit),
  .incStb(strb.incAddr), .curAddr(curAddr)
);

// File: tb/twowire_eeprom_test.sv
`timescale 1ns/1ps
module twowire_eeprom_test;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wrEn = 1'b1;
  logic sdaOe, sdaOut, bidirMode;
  logic busSda;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;

  assign busSda = sdaM & ~(sdaOe & ~sdaOut);

  twowire_eeprom uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(busSda), .wrEnIn(wrEn),
    .sdaOe(sdaOe), .sdaOut(sdaOut), .bidirMode(bidirMode)
  );

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sdaM = 1'b1; waitQ(Q);
  endtask

  task automatic bitOut(input logic b);
    sdaM = b;    waitQ(Q);
    sclM = 1'b1; waitQ(Q);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic bitIn(output logic b);
    sdaM = 1'b1; waitQ(Q);
    sclM = 1'b1; waitQ(Q/2);
    b = busSda;  waitQ(Q/2);
    sclM = 1'b0; waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bitOut(v[i]);
    bitIn(ack);
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitIn(v[i]);
    bitOut(!masterAck);
  endtask

  // write with stop; gate level at stop is given
  task automatic doWrite(input logic [7:0] wa, input logic [7:0] d, input logic gate,
                         input string req);
    logic a0, a1, a2;
    busStart();
    sendByte(8'hA0, a0);
    sendByte(wa, a1);
    sendByte(d, a2);
    check(req, {a0, a1, a2}, 3'b000);
    wrEn = gate;
    busStop();
    wrEn = 1'b1;
  endtask

  // random read of n bytes starting at wa
  task automatic doRead(input logic [7:0] wa, input int n, output logic [7:0] out [4]);
    logic a;
    busStart();
    sendByte(8'hA0, a);
    sendByte(wa, a);
    busStart();
    sendByte(8'hA1, a);
    for (int k = 0; k < n; k++) recvByte(k < n - 1, out[k]);
    busStop();
  endtask

  task automatic t_reset();
    check("R1 mode after reset", bidirMode, 1'b0);
    check("R2 no drive after reset", sdaOe, 1'b0);
  endtask

  task automatic t_premode();
    logic a;
    busStart();               // ignored: still transmit-only
    sendByte(8'hA0, a);
    check("R2 no ack for start before mode", a, 1'b1);
    check("R1 mode set by SCL fall", bidirMode, 1'b1);
    busStop();
  endtask

  task automatic t_writeRead();
    logic [7:0] r [4];
    doWrite(8'h05, 8'h3C, 1'b1, "R3 R4 acks on write");
    doRead(8'h05, 1, r);
    check("R6 random read", r[0], 8'h3C);
  endtask

  task automatic t_currentRead();
    logic a;
    logic [7:0] v;
    doWrite(8'h09, 8'h77, 1'b1, "R4 acks");
    busStart();
    sendByte(8'hA1, a);
    check("R3 read control acked", a, 1'b0);
    recvByte(1'b0, v);
    busStop();
    check("R9 current address read", v, 8'h77);
  endtask

  task automatic t_gate();
    logic [7:0] r [4];
    doWrite(8'h10, 8'h11, 1'b1, "R5 acks");
    doWrite(8'h10, 8'h55, 1'b0, "R5 acks gate low");
    doRead(8'h10, 1, r);
    check("R5 gate low blocks write", r[0], 8'h11);
    wrEn = 1'b0;
    begin
      logic a0, a1, a2;
      busStart();
      sendByte(8'hA0, a0);
      sendByte(8'h10, a1);
      sendByte(8'h66, a2);
      wrEn = 1'b1;           // raised only before stop
      busStop();
    end
    doRead(8'h10, 1, r);
    check("R5 gate sampled at stop", r[0], 8'h66);
  endtask

  task automatic t_addrMsb();
    logic [7:0] r [4];
    doWrite(8'h85, 8'h5A, 1'b1, "R4 acks");
    doRead(8'h05, 1, r);
    check("R4 word address bit 7 ignored", r[0], 8'h5A);
  endtask

  task automatic t_mismatch();
    logic a, b;
    busStart();
    sendByte(8'hA2, a);
    check("R3 wrong address not acked", a, 1'b1);
    sendByte(8'h00, b);
    check("R3 silent until next start", b, 1'b1);
    busStop();
    busStart();
    sendByte(8'hB1, a);
    check("R3 wrong read address not acked", a, 1'b1);
    busStop();
  endtask

  task automatic t_wrap();
    logic [7:0] r [4];
    doWrite(8'h7F, 8'hAB, 1'b1, "R7 setup");
    doWrite(8'h00, 8'hCD, 1'b1, "R7 setup");
    doWrite(8'h01, 8'hEF, 1'b1, "R7 setup");
    doRead(8'h7F, 3, r);
    check("R7 seq byte 0", r[0], 8'hAB);
    check("R7 seq wraps to 0", r[1], 8'hCD);
    check("R7 seq byte 2", r[2], 8'hEF);
  endtask

  task automatic t_nack();
    logic a;
    logic [7:0] v, after;
    doWrite(8'h30, 8'h00, 1'b1, "R8 setup");
    busStart();
    sendByte(8'hA0, a);
    sendByte(8'h30, a);
    busStart();
    sendByte(8'hA1, a);
    recvByte(1'b0, v);        // master NACK
    check("R8 byte before nack", v, 8'h00);
    for (int i = 7; i >= 0; i--) bitIn(after[i]);
    check("R8 released after nack", after, 8'hFF);
    busStop();
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] r [4];
    doWrite(8'h20, 8'h01, 1'b1, "R10 setup");
    busStart();
    sendByte(8'hA0, a);
    sendByte(8'h20, a);
    sendByte(8'h99, a);
    busStart();               // repeated start drops pending data
    sendByte(8'hA0, a);
    check("R10 control phase after restart", a, 1'b0);
    busStop();
    doRead(8'h20, 1, r);
    check("R10 pending write discarded", r[0], 8'h01);
    check("R1 mode still latched", bidirMode, 1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_premode();
    t_writeRead();
    t_currentRead();
    t_gate();
    t_addrMsb();
    t_mismatch();
    t_wrap();
    t_nack();
    t_restart();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule